// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the processor state update that follows the acceptance of an exception. A request carries a cause: external interrupt, break, non-maskable interrupt or bus fault. It also carries the current program counter, the delay-slot count, the status word, the stack pointer, the kernel stack pointer, the vector base and three candidate vector numbers. On acceptance the block works out the values for the return registers, the exception-status word, the new status word and the stack swap. It then makes a single 32-bit read of the vector table. When the read data returns, the new program counter is taken from it, and every register write is presented together in one completion cycle.

The status word is saved by stacking. The top two bits stay in place, the low twenty bits move up by ten positions, and the bottom ten bits become zero. Because the user-mode flag sits in that bottom field, the shift drops the processor into kernel mode. An exception taken inside a branch delay slot stores a return address that points back at the branch, so the branch runs again.

Top module: `exc_entry_seq`

## Requirements
- R1: For cause codes IRQ (1), BRK (2) and BUSF (4), the completion cycle asserts `erp_we_o` with `erp_o` as the return address. For NMI (3), it asserts `nrp_we_o` with `nrp_o` = PC, and `erp_we_o` stays low. Exactly one of the two strobes is high in that cycle.
- R2: The vector is 0 for NMI, the trap vector for BRK, the fault vector for BUSF and the interrupt vector for IRQ.
- R3: `exs_o` holds the low 8 bits of the vector in bits 15:8. All its other bits are zero.
- R4: The return address written to `erp_o` is PC minus the delay-slot count. `dslot_clr_o` pulses in the completion cycle whenever that count was nonzero.
- R5: If status bit 8 (user flag) was set at entry, the completion cycle asserts `usp_we_o` and `sp_we_o`, with `usp_o` = old SP and `sp_o` = kernel SP. If the bit was clear, neither strobe is asserted. The decision uses the status word from before the shift.
- R6: `ccs_o` = {old[31:30], old[19:0], ten zero bits}. For NMI, bit 30 (M flag) is cleared before the shift.
- R7: Exactly one read is issued, at address base + 4 × vector, modulo 2^32. `rd_valid_o` and `rd_addr_o` are held steady until `rd_ready_i` is high.
- R8: `pc_o` takes the read data. `done_o` pulses for one cycle in the cycle after the response, and all register write strobes appear only in that cycle.
- R9: `busy_o` rises in the cycle after acceptance and falls together with the `done_o` pulse. Requests presented while busy are ignored.
- R10: `pend_cause_o` shows the accepted cause while busy and shows NONE (0) once entry has completed.
- R11: After reset, `busy_o`, `rd_valid_o` and `done_o` are low and `pend_cause_o` is NONE.
- R12: A request with cause code 0 or 5 to 7 is ignored: no read is issued and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Exception request |
| req_cause_i | input | 3 | Cause code (1 IRQ, 2 BRK, 3 NMI, 4 BUSF) |
| pc_i | input | XLEN | Current program counter |
| dslot_i | input | DSLOT_W | Delay-slot count |
| ccs_i | input | XLEN | Current status word |
| sp_i | input | XLEN | Current stack pointer |
| ksp_i | input | XLEN | Kernel stack pointer |
| ebp_i | input | XLEN | Vector table base |
| trap_vec_i | input | VEC_W | Break vector |
| fault_vec_i | input | VEC_W | Bus-fault vector |
| irq_vec_i | input | VEC_W | Interrupt vector |
| rd_valid_o | output | 1 | Vector read request valid |
| rd_addr_o | output | XLEN | Vector read address |
| rd_ready_i | input | 1 | Read request accepted |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | XLEN | Read data |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | Entry complete, writes valid |
| pend_cause_o | output | 3 | Pending cause, 0 when none |
| erp_we_o | output | 1 | Exception return register write |
| erp_o | output | XLEN | Exception return value |
| nrp_we_o | output | 1 | NMI return register write |
| nrp_o | output | XLEN | NMI return value |
| exs_o | output | XLEN | Exception-status value |
| ccs_o | output | XLEN | Shifted status word |
| usp_we_o | output | 1 | User SP write |
| usp_o | output | XLEN | User SP value |
| sp_we_o | output | 1 | Stack pointer write |
| sp_o | output | XLEN | New stack pointer |
| dslot_clr_o | output | 1 | Clear delay-slot state |
| pc_o | output | XLEN | Handler address |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 8-bit vectors and a 2-bit delay-slot count. These settings make the largest slot count (3) and the largest vector (255) reachable, so the return-address subtraction and a vector-table address that wraps past 2^32 can both be checked. The read responder varies both its ready latency and its data latency, which covers back-to-back handshake phases as well as long waits. During those long waits the bench presents extra requests to confirm that they are dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [2:0] {
      EXC_NONE = 3'd0,
      EXC_IRQ  = 3'd1,
      EXC_BRK  = 3'd2,
      EXC_NMI  = 3'd3,
      EXC_BUSF = 3'd4
   } exc_cause_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_ADDR = 2'd1,
      FS_WAIT = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/exc_ccs_shift.sv
module exc_ccs_shift #(
   parameter int XLEN   = 32,
   parameter int KEEP_W = 2,
   parameter int SHIFT  = 10,
   parameter int M_BIT  = 30
) (
   input  logic [XLEN-1:0] ccs_i,
   input  logic            clr_m_i,
   output logic [XLEN-1:0] ccs_o
);
   localparam int MID_W = XLEN - KEEP_W - SHIFT;

   if (MID_W < 1) begin : g_bad_geom
      $error("exc_ccs_shift: KEEP_W + SHIFT must be below XLEN");
   end
   if (M_BIT >= XLEN) begin : g_bad_m
      $error("exc_ccs_shift: M_BIT out of range");
   end

   logic [XLEN-1:0] masked;

   always_comb begin
      masked = ccs_i;
      if (clr_m_i) masked[M_BIT] = 1'b0;
   end

   if (KEEP_W > 0) begin : g_keep
      assign ccs_o = {masked[XLEN-1 -: KEEP_W], masked[MID_W-1:0], {SHIFT{1'b0}}};
   end else begin : g_nokeep
      assign ccs_o = {masked[MID_W-1:0], {SHIFT{1'b0}}};
   end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
   import exc_entry_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int VEC_W   = 8,
   parameter int DSLOT_W = 2,
   parameter int U_BIT   = 8,
   parameter int M_BIT   = 30,
   parameter int KEEP_W  = 2,
   parameter int SHIFT   = 10,
   parameter int EXS_LSB = 8,
   parameter int EXS_W   = 8
) (
   input  exc_cause_e          cause_i,
   input  logic [XLEN-1:0]     pc_i,
   input  logic [DSLOT_W-1:0]  dslot_i,
   input  logic [XLEN-1:0]     ccs_i,
   input  logic [XLEN-1:0]     sp_i,
   input  logic [XLEN-1:0]     ksp_i,
   input  logic [XLEN-1:0]     ebp_i,
   input  logic [VEC_W-1:0]    trap_vec_i,
   input  logic [VEC_W-1:0]    fault_vec_i,
   input  logic [VEC_W-1:0]    irq_vec_i,
   output logic                to_erp_o,
   output logic [XLEN-1:0]     erp_o,
   output logic [XLEN-1:0]     nrp_o,
   output logic [XLEN-1:0]     exs_o,
   output logic [XLEN-1:0]     ccs_o,
   output logic                swap_o,
   output logic [XLEN-1:0]     usp_o,
   output logic [XLEN-1:0]     sp_o,
   output logic                dslot_nz_o,
   output logic [XLEN-1:0]     addr_o
);
   if (U_BIT >= SHIFT) begin : g_bad_u
      $error("exc_entry_calc: user flag must lie in the cleared field");
   end
   if (EXS_LSB + EXS_W > XLEN) begin : g_bad_exs
      $error("exc_entry_calc: status index field exceeds word");
   end

   logic [VEC_W-1:0] vec;
   logic [XLEN-1:0]  vec_ext;
   logic             is_nmi;

   assign is_nmi = (cause_i == EXC_NMI);

   always_comb begin
      unique case (cause_i)
         EXC_BRK:  vec = trap_vec_i;
         EXC_BUSF: vec = fault_vec_i;
         EXC_IRQ:  vec = irq_vec_i;
         default:  vec = '0;
      endcase
   end

   assign vec_ext    = XLEN'(vec);
   assign to_erp_o   = !is_nmi;
   assign erp_o      = pc_i - XLEN'(dslot_i);
   assign nrp_o      = pc_i;
   assign dslot_nz_o = |dslot_i;
   assign swap_o     = ccs_i[U_BIT];
   assign usp_o      = sp_i;
   assign sp_o       = ksp_i;
   assign addr_o     = ebp_i + (vec_ext << 2);

   always_comb begin
      exs_o = '0;
      exs_o[EXS_LSB +: EXS_W] = vec_ext[EXS_W-1:0];
   end

   exc_ccs_shift #(
      .XLEN  (XLEN),
      .KEEP_W(KEEP_W),
      .SHIFT (SHIFT),
      .M_BIT (M_BIT)
   ) shift_i (
      .ccs_i  (ccs_i),
      .clr_m_i(is_nmi),
      .ccs_o  (ccs_o)
   );
endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
   import exc_entry_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [XLEN-1:0] addr_i,
   output logic            busy_o,
   output logic            rd_valid_o,
   output logic [XLEN-1:0] rd_addr_o,
   input  logic            rd_ready_i,
   input  logic            rsp_valid_i,
   input  logic [XLEN-1:0] rsp_data_i,
   output logic            done_o,
   output logic [XLEN-1:0] pc_o
);
   fetch_state_e    state_q;
   logic [XLEN-1:0] addr_q;
   logic            done_q;
   logic [XLEN-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         addr_q  <= '0;
         done_q  <= 1'b0;
         pc_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            FS_IDLE: if (start_i) begin
               state_q <= FS_ADDR;
               addr_q  <= addr_i;
            end
            FS_ADDR: if (rd_ready_i) state_q <= FS_WAIT;
            FS_WAIT: if (rsp_valid_i) begin
               state_q <= FS_IDLE;
               pc_q    <= rsp_data_i;
               done_q  <= 1'b1;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != FS_IDLE);
   assign rd_valid_o = (state_q == FS_ADDR);
   assign rd_addr_o  = addr_q;
   assign done_o     = done_q;
   assign pc_o       = pc_q;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int VEC_W   = 8,
   parameter int DSLOT_W = 2,
   parameter int U_BIT   = 8,
   parameter int M_BIT   = 30,
   parameter int KEEP_W  = 2,
   parameter int SHIFT   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [2:0]         req_cause_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [DSLOT_W-1:0] dslot_i,
   input  logic [XLEN-1:0]    ccs_i,
   input  logic [XLEN-1:0]    sp_i,
   input  logic [XLEN-1:0]    ksp_i,
   input  logic [XLEN-1:0]    ebp_i,
   input  logic [VEC_W-1:0]   trap_vec_i,
   input  logic [VEC_W-1:0]   fault_vec_i,
   input  logic [VEC_W-1:0]   irq_vec_i,
   output logic               rd_valid_o,
   output logic [XLEN-1:0]    rd_addr_o,
   input  logic               rd_ready_i,
   input  logic               rsp_valid_i,
   input  logic [XLEN-1:0]    rsp_data_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [2:0]         pend_cause_o,
   output logic               erp_we_o,
   output logic [XLEN-1:0]    erp_o,
   output logic               nrp_we_o,
   output logic [XLEN-1:0]    nrp_o,
   output logic [XLEN-1:0]    exs_o,
   output logic [XLEN-1:0]    ccs_o,
   output logic               usp_we_o,
   output logic [XLEN-1:0]    usp_o,
   output logic               sp_we_o,
   output logic [XLEN-1:0]    sp_o,
   output logic               dslot_clr_o,
   output logic [XLEN-1:0]    pc_o
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("exc_entry_seq: vector table entries are 32-bit words");
   end

   exc_cause_e      cause_in;
   logic            cause_ok;
   logic            accept;
   logic            busy;
   logic            done;

   logic            c_to_erp, c_swap, c_dnz;
   logic [XLEN-1:0] c_erp, c_nrp, c_exs, c_ccs, c_usp, c_sp, c_addr;

   exc_cause_e      cause_q;
   logic            to_erp_q, swap_q, dnz_q;
   logic [XLEN-1:0] erp_q, nrp_q, exs_q, ccs_q, usp_q, sp_q;

   assign cause_in = exc_cause_e'(req_cause_i);
   assign cause_ok = (req_cause_i >= 3'd1) && (req_cause_i <= 3'd4);
   assign accept   = req_valid_i && cause_ok && !busy;

   exc_entry_calc #(
      .XLEN   (XLEN),
      .VEC_W  (VEC_W),
      .DSLOT_W(DSLOT_W),
      .U_BIT  (U_BIT),
      .M_BIT  (M_BIT),
      .KEEP_W (KEEP_W),
      .SHIFT  (SHIFT)
   ) calc_i (
      .cause_i    (cause_in),
      .pc_i       (pc_i),
      .dslot_i    (dslot_i),
      .ccs_i      (ccs_i),
      .sp_i       (sp_i),
      .ksp_i      (ksp_i),
      .ebp_i      (ebp_i),
      .trap_vec_i (trap_vec_i),
      .fault_vec_i(fault_vec_i),
      .irq_vec_i  (irq_vec_i),
      .to_erp_o   (c_to_erp),
      .erp_o      (c_erp),
      .nrp_o      (c_nrp),
      .exs_o      (c_exs),
      .ccs_o      (c_ccs),
      .swap_o     (c_swap),
      .usp_o      (c_usp),
      .sp_o       (c_sp),
      .dslot_nz_o (c_dnz),
      .addr_o     (c_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q  <= EXC_NONE;
         to_erp_q <= 1'b0;
         swap_q   <= 1'b0;
         dnz_q    <= 1'b0;
         erp_q    <= '0;
         nrp_q    <= '0;
         exs_q    <= '0;
         ccs_q    <= '0;
         usp_q    <= '0;
         sp_q     <= '0;
      end else if (accept) begin
         cause_q  <= cause_in;
         to_erp_q <= c_to_erp;
         swap_q   <= c_swap;
         dnz_q    <= c_dnz;
         erp_q    <= c_erp;
         nrp_q    <= c_nrp;
         exs_q    <= c_exs;
         ccs_q    <= c_ccs;
         usp_q    <= c_usp;
         sp_q     <= c_sp;
      end
   end

   exc_vec_fetch #(
      .XLEN(XLEN)
   ) fetch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept),
      .addr_i     (c_addr),
      .busy_o     (busy),
      .rd_valid_o (rd_valid_o),
      .rd_addr_o  (rd_addr_o),
      .rd_ready_i (rd_ready_i),
      .rsp_valid_i(rsp_valid_i),
      .rsp_data_i (rsp_data_i),
      .done_o     (done),
      .pc_o       (pc_o)
   );

   assign busy_o       = busy;
   assign done_o       = done;
   assign pend_cause_o = busy ? cause_q : EXC_NONE;
   assign erp_we_o     = done && to_erp_q;
   assign nrp_we_o     = done && !to_erp_q;
   assign usp_we_o     = done && swap_q;
   assign sp_we_o      = done && swap_q;
   assign dslot_clr_o  = done && dnz_q;
   assign erp_o        = erp_q;
   assign nrp_o        = nrp_q;
   assign exs_o        = exs_q;
   assign ccs_o        = ccs_q;
   assign usp_o        = usp_q;
   assign sp_o         = sp_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int XLEN  = 32,
   parameter int SHIFT = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            rd_valid,
   input logic            rd_ready,
   input logic [XLEN-1:0] rd_addr,
   input logic            done,
   input logic [2:0]      pend_cause,
   input logic            erp_we,
   input logic            nrp_we,
   input logic            usp_we,
   input logic            sp_we,
   input logic            dslot_clr,
   input logic [XLEN-1:0] exs,
   input logic [XLEN-1:0] ccs
);
   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

   assert_rd_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);

   assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_pend_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend_cause == 3'd0);

   assert_one_ret_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({erp_we, nrp_we}) == 1);

   assert_writes_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (erp_we || nrp_we || usp_we || sp_we || dslot_clr) |-> done);

   assert_exs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (exs[7:0] == 8'd0) && (exs[XLEN-1:16] == '0));

   assert_ccs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ccs[SHIFT-1:0] == '0);
endmodule

bind exc_entry_seq exc_entry_chk #(
   .XLEN (XLEN),
   .SHIFT(SHIFT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy_o),
   .rd_valid  (rd_valid_o),
   .rd_ready  (rd_ready_i),
   .rd_addr   (rd_addr_o),
   .done      (done_o),
   .pend_cause(pend_cause_o),
   .erp_we    (erp_we_o),
   .nrp_we    (nrp_we_o),
   .usp_we    (usp_we_o),
   .sp_we     (sp_we_o),
   .dslot_clr (dslot_clr_o),
   .exs       (exs_o),
   .ccs       (ccs_o)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_cause = 3'd0;
   logic [31:0] pc = '0, ccs = '0, sp = '0, ksp = '0, ebp = '0;
   logic [1:0]  dslot = '0;
   logic [7:0]  tv = '0, fv = '0, iv = '0;
   logic        rd_valid, rd_ready = 1'b0, rsp_valid = 1'b0;
   logic [31:0] rd_addr, rsp_data = '0;
   logic        busy, done, erp_we, nrp_we, usp_we, sp_we, dslot_clr;
   logic [2:0]  pend;
   logic [31:0] erp, nrp, exs, ccs_n, usp, sp_n, pc_n;

   always #5 clk = ~clk;

   exc_entry_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_cause_i(req_cause),
      .pc_i(pc), .dslot_i(dslot), .ccs_i(ccs), .sp_i(sp), .ksp_i(ksp), .ebp_i(ebp),
      .trap_vec_i(tv), .fault_vec_i(fv), .irq_vec_i(iv),
      .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
      .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
      .busy_o(busy), .done_o(done), .pend_cause_o(pend),
      .erp_we_o(erp_we), .erp_o(erp), .nrp_we_o(nrp_we), .nrp_o(nrp),
      .exs_o(exs), .ccs_o(ccs_n), .usp_we_o(usp_we), .usp_o(usp),
      .sp_we_o(sp_we), .sp_o(sp_n), .dslot_clr_o(dslot_clr), .pc_o(pc_n)
   );

   typedef struct {
      logic        erp_we;
      logic [31:0] erp;
      logic        nrp_we;
      logic [31:0] nrp;
      logic [31:0] exs;
      logic [31:0] ccs;
      logic        swap;
      logic [31:0] usp;
      logic [31:0] sp;
      logic        dclr;
      logic [31:0] addr;
      logic [31:0] pc;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0, n_fail = 0, n_done = 0, n_reads = 0, n_sent = 0;
   int          rdy_lat = 0, rsp_lat = 0;
   logic [31:0] seen_addr = '0;

   function automatic logic [31:0] memf(logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'hC3C3_0F0F;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // vector table responder
   initial begin
      forever begin
         @(negedge clk);
         if (rd_valid) begin
            repeat (rdy_lat) @(negedge clk);
            seen_addr = rd_addr;
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            n_reads++;
            repeat (rsp_lat) @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = memf(seen_addr);
            @(negedge clk);
            rsp_valid = 1'b0;
         end
      end
   end

   // monitor: compare completed entries against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            exp_t e;
            n_done++;
            if (sb.size() == 0) begin
               chk("R9", "unexpected completion", 32'd1, 32'd0);
            end else begin
               e = sb.pop_front();
               chk("R1", "erp_we", {31'd0, erp_we}, {31'd0, e.erp_we});
               chk("R1", "nrp_we", {31'd0, nrp_we}, {31'd0, e.nrp_we});
               if (e.erp_we) chk("R4", "erp value", erp, e.erp);
               if (e.nrp_we) chk("R1", "nrp value", nrp, e.nrp);
               chk("R3", "exs", exs, e.exs);
               chk("R6", "ccs", ccs_n, e.ccs);
               chk("R5", "usp_we", {31'd0, usp_we}, {31'd0, e.swap});
               chk("R5", "sp_we", {31'd0, sp_we}, {31'd0, e.swap});
               if (e.swap) begin
                  chk("R5", "usp", usp, e.usp);
                  chk("R5", "sp", sp_n, e.sp);
               end
               chk("R4", "dslot_clr", {31'd0, dslot_clr}, {31'd0, e.dclr});
               chk("R7", "read addr R2", seen_addr, e.addr);
               chk("R8", "pc", pc_n, e.pc);
               chk("R10", "pending cleared", {29'd0, pend}, 32'd0);
               chk("R9", "busy low at done", {31'd0, busy}, 32'd0);
            end
         end
      end
   end

   task automatic send(input logic [2:0] c, input logic [31:0] p, input logic [1:0] d,
                       input logic [31:0] s, input logic [31:0] spv, input logic [31:0] k,
                       input logic [31:0] b, input logic [7:0] t, input logic [7:0] f,
                       input logic [7:0] i, input int rl, input int pl, input bit extra);
      exp_t        e;
      logic [7:0]  vec;
      logic [31:0] s1;
      vec = (c == 3'd3) ? 8'd0 : (c == 3'd2) ? t : (c == 3'd4) ? f : i;
      s1  = s;
      if (c == 3'd3) s1[30] = 1'b0;
      e.erp_we = (c != 3'd3);
      e.nrp_we = (c == 3'd3);
      e.erp    = p - {30'd0, d};
      e.nrp    = p;
      e.exs    = {16'd0, vec, 8'd0};
      e.ccs    = {s1[31:30], s1[19:0], 10'd0};
      e.swap   = s[8];
      e.usp    = spv;
      e.sp     = k;
      e.dclr   = (d != 2'd0);
      e.addr   = b + {22'd0, vec, 2'b00};
      e.pc     = memf(e.addr);
      sb.push_back(e);
      n_sent++;
      rdy_lat = rl;
      rsp_lat = pl;
      @(negedge clk);
      req_cause = c; pc = p; dslot = d; ccs = s; sp = spv; ksp = k; ebp = b;
      tv = t; fv = f; iv = i;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "busy after accept", {31'd0, busy}, 32'd1);
      chk("R10", "pending cause", {29'd0, pend}, {29'd0, c});
      if (extra) begin
         req_cause = 3'd2; tv = 8'h77; pc = 32'hDEAD_0000;
         req_valid = 1'b1;
         repeat (2) @(negedge clk);
         req_valid = 1'b0;
      end
      while (sb.size() != 0) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "busy", {31'd0, busy}, 32'd0);
      chk("R11", "rd_valid", {31'd0, rd_valid}, 32'd0);
      chk("R11", "done", {31'd0, done}, 32'd0);
      chk("R11", "pend", {29'd0, pend}, 32'd0);

      // R1 R2 R5: interrupt from user mode
      send(3'd1, 32'h0000_1000, 2'd0, 32'hC00A_5F3F, 32'h0BAD_F00D, 32'h8000_0000,
           32'h4000_0000, 8'h11, 8'h22, 8'h33, 0, 0, 1'b0);
      // R2 R4: break in delay slot, kernel mode
      send(3'd2, 32'h0000_2002, 2'd2, 32'h4000_0000, 32'h1111_1111, 32'h2222_2222,
           32'h0000_8000, 8'h40, 8'h50, 8'h60, 2, 1, 1'b0);
      // R4 R5 R6: bus fault, slot 3, all-ones status
      send(3'd4, 32'h0000_0001, 2'd3, 32'hFFFF_FFFF, 32'hAAAA_0000, 32'h5555_0000,
           32'h0010_0000, 8'h01, 8'hFE, 8'h02, 1, 3, 1'b0);
      // R1 R6: NMI, M set, user mode, delay slot
      send(3'd3, 32'h1234_5678, 2'd1, 32'h4000_0100, 32'h0000_0ABC, 32'h0000_0DEF,
           32'h0200_0000, 8'h09, 8'h08, 8'h07, 0, 2, 1'b0);
      // R7: vector 255 wraps the table address
      send(3'd1, 32'hFFFF_FFF0, 2'd0, 32'h0000_0000, 32'h0, 32'h0,
           32'hFFFF_FF10, 8'h00, 8'h00, 8'hFF, 3, 0, 1'b0);
      // R9: requests while busy are ignored
      send(3'd4, 32'h0000_4444, 2'd0, 32'h8000_0000, 32'h0, 32'h0,
           32'h0000_0000, 8'h00, 8'h0C, 8'h00, 5, 4, 1'b1);
      repeat (4) @(negedge clk);
      chk("R9", "completions", n_done, n_sent);
      chk("R7", "reads", n_reads, n_sent);

      // R12: invalid causes ignored
      req_cause = 3'd0; req_valid = 1'b1;
      @(negedge clk);
      req_cause = 3'd6;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12", "busy", {31'd0, busy}, 32'd0);
      chk("R12", "rd_valid", {31'd0, rd_valid}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R12", "reads", n_reads, n_sent);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule